// File: doc/BRIEF.md
# Parallel Code-Group Descrambler with Lock Hold Timer

This block recovers plain 5-bit NRZ code-groups from a receive stream that a transmitter scrambled with an 11-stage additive keystream (recurrence k[n] = k[n-9] XOR k[n-11]). It handles one code-group per clock. The descrambler runs its own copy of the keystream and XORs it onto the received bits. The output groups are not yet aligned to code-group boundaries. Alignment, clock recovery and line decoding happen elsewhere.

The descrambler has no lock at reset. To acquire lock it relies on the idle line. Idle plaintext is all ones, so the keystream is the complement of the received bits. While hunting, it loads its keystream history from the inverted received bits. Once enough history is present, it checks each new group against the keystream it predicts. A run of consecutive correct predictions declares lock. After lock the keystream runs freely. A hold timer then requires a minimum number of decoded idle groups in every window, and lock is dropped when the window ends without them. A bypass control routes the received groups straight to the output.

Top module: `descrambler_hold`

## Requirements
- R1: While locked and not bypassed, a valid input group `in_data` appears one clock later on `out_data` XORed with the keystream, with `out_valid` high. Bit 0 of a group is the earliest bit in time. The keystream obeys k[n] = k[n-9] XOR k[n-11].
- R2: While `rst` is high and on the cycle after it, `locked` and `out_valid` are low and `out_data` is zero.
- R3: In hunt, the first 3 valid groups after reset only fill the history. Each later valid group is compared against the prediction. `locked` rises at the clock edge that takes in the LOCK_IDLES-th consecutive matching idle. With the default of 16, that is the 19th idle group.
- R4: In hunt, a compared group that does not decode to 11111 clears the match run and restarts the 3-group fill. After such a group, 19 more idle groups are needed to lock.
- R5: While unlocked and not bypassed, `out_valid` is low and `out_data` is zero.
- R6: While locked, a timer counts clock cycles from lock entry or from its last restart. If no restart happens, `locked` falls at the HOLD_CYCLES-th edge after that point.
- R7: While locked, the edge that takes in the HOLD_IDLES-th decoded idle (11111) since the last restart restarts the timer.
- R8: After lock is lost, acquisition starts again from an empty fill, exactly as in R3.
- R9: A cycle with `in_valid` low does not advance the keystream. In non-bypass mode it gives `out_valid` low and `out_data` zero on the next cycle.
- R10: With `bypass` high, `out_data` and `out_valid` copy `in_data` and `in_valid` one cycle later. Lock tracking and the keystream carry on as usual during bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received group is present |
| in_data | input | 5 | Scrambled NRZ group, bit 0 earliest |
| bypass | input | 1 | Pass received groups through unchanged |
| out_data | output | 5 | Descrambled (or bypassed) group |
| out_valid | output | 1 | `out_data` holds a group |
| locked | output | 1 | Keystream is synchronised |

## Verification
Every result is registered once. A group driven before edge E shows on `out_data`/`out_valid` just after E. A change of `locked` also shows just after the edge that takes in the triggering group or ends the window. The bench drives each group at the falling edge and samples 1 ns after the rising edge that consumes it. Each check is therefore tied to a counted edge. These are the lock edge at the 19th idle, the drop at the 40th edge of the shortened hold window, and the drop 40 edges after a restart made by the third idle.

// File: rtl/ds_pkg.sv
package ds_pkg;

    localparam int GRP_W    = 5;
    localparam int LFSR_LEN = 11;
    localparam int TAP_NEAR = 9;
    localparam int FILL_GROUPS = (LFSR_LEN + GRP_W - 1) / GRP_W;

    typedef logic [GRP_W-1:0]    grp_t;
    typedef logic [LFSR_LEN-1:0] hist_t;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_st_t;

    typedef struct packed {
        logic valid;
        grp_t data;
    } beat_t;

    localparam grp_t IDLE_GRP = '1;

    // hist[0] is the most recent keystream bit, hist[i] is i+1 bits back.
    function automatic grp_t predict_keys(hist_t h);
        grp_t p;
        for (int j = 0; j < GRP_W; j++) begin
            p[j] = h[TAP_NEAR - 1 - j] ^ h[LFSR_LEN - 1 - j];
        end
        return p;
    endfunction

    function automatic hist_t push_group(hist_t h, grp_t b);
        hist_t n;
        n = h;
        for (int j = 0; j < GRP_W; j++) begin
            n = {n[LFSR_LEN-2:0], b[j]};
        end
        return n;
    endfunction

endpackage

// File: rtl/ds_keystream.sv
module ds_keystream
    import ds_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic follow_line,
    input  grp_t line_grp,
    output grp_t key_grp
);

    hist_t hist_q;
    grp_t  load_bits;

    assign key_grp = predict_keys(hist_q);

    // Hunting assumes idle plaintext: the key is the inverted line.
    assign load_bits = follow_line ? ~line_grp : key_grp;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (advance) begin
            hist_q <= push_group(hist_q, load_bits);
        end
    end

endmodule

// File: rtl/ds_sync_ctrl.sv
module ds_sync_ctrl
    import ds_pkg::*;
#(
    parameter int LOCK_IDLES  = 16,
    parameter int HOLD_CYCLES = 18050,
    parameter int HOLD_IDLES  = 8,
    localparam int T_W = $clog2(HOLD_CYCLES + 1),
    localparam int R_W = $clog2(LOCK_IDLES + 1),
    localparam int I_W = $clog2(HOLD_IDLES + 1),
    localparam int F_W = $clog2(FILL_GROUPS + 1)
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           grp_valid,
    input  grp_t           decoded,
    output logic           locked,
    output logic [T_W-1:0] hold_t
);

    sync_st_t       st_q;
    logic [F_W-1:0] fill_q;
    logic [R_W-1:0] run_q;
    logic [I_W-1:0] idles_q;
    logic [T_W-1:0] t_q;

    logic is_idle;
    logic filled;
    logic refresh;
    logic expire;

    assign is_idle = grp_valid && (decoded == IDLE_GRP);
    assign filled  = (fill_q == F_W'(FILL_GROUPS));
    assign refresh = is_idle && (idles_q == I_W'(HOLD_IDLES - 1));
    assign expire  = (t_q == T_W'(HOLD_CYCLES - 1));

    assign locked = (st_q == ST_LOCK);
    assign hold_t = t_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_HUNT;
            fill_q  <= '0;
            run_q   <= '0;
            idles_q <= '0;
            t_q     <= '0;
        end else begin
            unique case (st_q)
                ST_HUNT: begin
                    if (grp_valid) begin
                        if (!filled) begin
                            fill_q <= fill_q + 1'b1;
                        end else if (is_idle) begin
                            if (run_q == R_W'(LOCK_IDLES - 1)) begin
                                st_q    <= ST_LOCK;
                                run_q   <= '0;
                                t_q     <= '0;
                                idles_q <= '0;
                            end else begin
                                run_q <= run_q + 1'b1;
                            end
                        end else begin
                            fill_q <= '0;
                            run_q  <= '0;
                        end
                    end
                end
                ST_LOCK: begin
                    if (refresh) begin
                        t_q     <= '0;
                        idles_q <= '0;
                    end else if (expire) begin
                        st_q    <= ST_HUNT;
                        fill_q  <= '0;
                        run_q   <= '0;
                        t_q     <= '0;
                        idles_q <= '0;
                    end else begin
                        t_q <= t_q + 1'b1;
                        if (is_idle) begin
                            idles_q <= idles_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/ds_out_stage.sv
module ds_out_stage
    import ds_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bypass,
    input  logic  locked,
    input  beat_t line_beat,
    input  grp_t  decoded,
    output beat_t out_beat
);

    beat_t nxt;

    always_comb begin
        if (bypass) begin
            nxt = line_beat;
        end else if (locked && line_beat.valid) begin
            nxt.valid = 1'b1;
            nxt.data  = decoded;
        end else begin
            nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_beat <= '0;
        end else begin
            out_beat <= nxt;
        end
    end

endmodule

// File: rtl/descrambler_hold.sv
module descrambler_hold
    import ds_pkg::*;
#(
    parameter int LOCK_IDLES  = 16,
    parameter int HOLD_CYCLES = 18050,
    parameter int HOLD_IDLES  = 8,
    localparam int T_W = $clog2(HOLD_CYCLES + 1)
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [4:0] in_data,
    input  logic       bypass,
    output logic [4:0] out_data,
    output logic       out_valid,
    output logic       locked
);

    grp_t           key_grp;
    grp_t           decoded;
    logic           lock_w;
    logic [T_W-1:0] hold_t;
    beat_t          line_beat;
    beat_t          out_beat;

    assign decoded         = in_data ^ key_grp;
    assign line_beat.valid = in_valid;
    assign line_beat.data  = in_data;

    ds_keystream u_key (
        .clk         (clk),
        .rst         (rst),
        .advance     (in_valid),
        .follow_line (!lock_w),
        .line_grp    (in_data),
        .key_grp     (key_grp)
    );

    ds_sync_ctrl #(
        .LOCK_IDLES  (LOCK_IDLES),
        .HOLD_CYCLES (HOLD_CYCLES),
        .HOLD_IDLES  (HOLD_IDLES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .grp_valid (in_valid),
        .decoded   (decoded),
        .locked    (lock_w),
        .hold_t    (hold_t)
    );

    ds_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .bypass    (bypass),
        .locked    (lock_w),
        .line_beat (line_beat),
        .decoded   (decoded),
        .out_beat  (out_beat)
    );

    assign out_data  = out_beat.data;
    assign out_valid = out_beat.valid;
    assign locked    = lock_w;

endmodule

// File: rtl/ds_hold_chk.sv
module ds_hold_chk #(
    parameter int HOLD_CYCLES = 18050,
    parameter int T_W = 15
)(
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [4:0]     in_data,
    input logic           bypass,
    input logic [4:0]     out_data,
    input logic           out_valid,
    input logic           locked,
    input logic [T_W-1:0] hold_t
);

    assert_reset_quiet_R2: assert property (@(posedge clk)
        rst |=> (!locked && !out_valid && out_data == 5'd0));

    assert_unlocked_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !locked) |=> (!out_valid && out_data == 5'd0));

    assert_gap_no_output_R9: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !in_valid) |=> !out_valid);

    assert_bypass_copy_R10: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (out_data == $past(in_data) && out_valid == $past(in_valid)));

    assert_lock_needs_group_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(in_valid));

    assert_timer_in_window_R6: assert property (@(posedge clk) disable iff (rst)
        locked |-> (hold_t < T_W'(HOLD_CYCLES)));

    assert_drop_at_window_end_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> ($past(hold_t) == T_W'(HOLD_CYCLES - 1)));

    assert_fresh_window_on_lock_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (hold_t == '0));

endmodule

bind descrambler_hold ds_hold_chk #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .T_W         (T_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .bypass    (bypass),
    .out_data  (out_data),
    .out_valid (out_valid),
    .locked    (locked),
    .hold_t    (hold_t)
);

// File: tb/sim_descrambler_hold.sv
`timescale 1ns/1ps
module sim_descrambler_hold;

    localparam int LOCKN = 16;
    localparam int HOLDC = 40;
    localparam int HOLDI = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [4:0] in_data = 5'd0;
    logic       bypass = 1'b0;
    logic [4:0] out_data;
    logic       out_valid;
    logic       locked;

    int n_chk  = 0;
    int n_fail = 0;
    logic [10:0] ks = 11'h5A3;
    logic [4:0]  last_sd;

    always #2.5 clk = ~clk;

    descrambler_hold #(
        .LOCK_IDLES  (LOCKN),
        .HOLD_CYCLES (HOLDC),
        .HOLD_IDLES  (HOLDI)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .bypass    (bypass),
        .out_data  (out_data),
        .out_valid (out_valid),
        .locked    (locked)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Serial keystream: new bit = bit 9 back XOR bit 11 back; bit 0 first.
    task automatic next_key(output logic [4:0] k);
        for (int j = 0; j < 5; j++) begin
            logic nb;
            nb = ks[8] ^ ks[10];
            k[j] = nb;
            ks = {ks[9:0], nb};
        end
    endtask

    task automatic send(input logic [4:0] d, input logic v, input logic byp);
        logic [4:0] k;
        @(negedge clk);
        if (v) begin
            next_key(k);
            last_sd = d ^ k;
        end else begin
            last_sd = 5'h15;
        end
        in_valid = v;
        in_data  = last_sd;
        bypass   = byp;
        @(posedge clk);
        #1;
    endtask

    task automatic acquire(input string req);
        for (int i = 1; i <= 19; i++) begin
            send(5'h1F, 1'b1, 1'b0);
            if (i < 19) begin
                check({req, " no lock before 19th idle"}, {4'd0, locked}, 5'd0);
            end else begin
                check({req, " lock at 19th idle"}, {4'd0, locked}, 5'd1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R2 locked in reset", {4'd0, locked}, 5'd0);
        check("R2 out_valid in reset", {4'd0, out_valid}, 5'd0);
        check("R2 out_data in reset", out_data, 5'd0);
        @(negedge clk);
        rst = 1'b0;

        // R10 bypass while unlocked, invalid so the keystream does not move
        send(5'h00, 1'b0, 1'b1);
        check("R10 bypass raw data unlocked", out_data, last_sd);
        check("R10 bypass valid copy", {4'd0, out_valid}, 5'd0);

        // R3 acquisition with R5 silence during hunt
        for (int i = 1; i <= 19; i++) begin
            send(5'h1F, 1'b1, 1'b0);
            if (i < 19) begin
                check("R3 no lock yet", {4'd0, locked}, 5'd0);
                check("R5 silent while hunting", {out_valid, out_data}, 5'd0);
            end else begin
                check("R3 lock at 19th idle", {4'd0, locked}, 5'd1);
            end
        end

        // R1 exhaustive group sweep with idles often enough to hold lock
        for (int v = 0; v < 32; v++) begin
            send(5'(v), 1'b1, 1'b0);
            check("R1 decoded data", out_data, 5'(v));
            check("R1 out_valid", {4'd0, out_valid}, 5'd1);
            if (v % 4 == 3) begin
                send(5'h1F, 1'b1, 1'b0);
                check("R1 decoded idle", out_data, 5'h1F);
            end
        end

        // R9 gaps do not advance keystream
        for (int g = 0; g < 3; g++) begin
            send(5'h00, 1'b0, 1'b0);
            check("R9 gap out_valid low", {4'd0, out_valid}, 5'd0);
            check("R9 gap out_data zero", out_data, 5'd0);
            send(5'h0A + 5'(g), 1'b1, 1'b0);
            check("R9 data after gap", out_data, 5'h0A + 5'(g));
            send(5'h1F, 1'b1, 1'b0);
            check("R9 idle after gap", out_data, 5'h1F);
        end

        // R10 bypass while locked, keystream keeps step
        for (int b = 0; b < 6; b++) begin
            send(5'h1F, 1'b1, 1'b1);
            check("R10 bypass raw data", out_data, last_sd);
            check("R10 bypass valid", {4'd0, out_valid}, 5'd1);
        end
        send(5'h00, 1'b0, 1'b1);
        check("R10 bypass invalid copy", {4'd0, out_valid}, 5'd0);
        check("R10 bypass raw data on gap", out_data, 5'h15);
        send(5'h13, 1'b1, 1'b0);
        check("R10 decode after bypass", out_data, 5'h13);
        check("R10 still locked", {4'd0, locked}, 5'd1);

        // Drain to loss of lock to reach a known state
        for (int w = 0; w < 60 && locked; w++) begin
            send(5'h04, 1'b1, 1'b0);
        end
        check("R6 lock eventually lost", {4'd0, locked}, 5'd0);

        // R8 reacquire, then R6 window with too few idles
        acquire("R8");
        for (int k = 1; k <= HOLDC; k++) begin
            send((k <= 2) ? 5'h1F : 5'h06, 1'b1, 1'b0);
            if (k < HOLDC) begin
                check("R6 held within window", {4'd0, locked}, 5'd1);
            end else begin
                check("R6 drop at window end", {4'd0, locked}, 5'd0);
            end
        end

        // R7 restart by third idle
        acquire("R8");
        for (int k = 1; k <= 48; k++) begin
            send((k >= 6 && k <= 8) ? 5'h1F : 5'h09, 1'b1, 1'b0);
            if (k == 40) check("R7 restarted window survives", {4'd0, locked}, 5'd1);
            if (k == 47) check("R7 held until restart plus window", {4'd0, locked}, 5'd1);
            if (k == 48) check("R7 drop 40 edges after restart", {4'd0, locked}, 5'd0);
        end

        // R4 mismatch in hunt restarts fill
        for (int i = 0; i < 10; i++) begin
            send(5'h1F, 1'b1, 1'b0);
        end
        send(5'h00, 1'b1, 1'b0);
        check("R4 no lock after mismatch", {4'd0, locked}, 5'd0);
        acquire("R4");
        send(5'h11, 1'b1, 1'b0);
        check("R4 decode after relock", out_data, 5'h11);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule